// File: doc/BRIEF.md
# Prescaled PWM Timer

This block generates one pulse-width-modulated output from a 16-bit up-counter. The counter advances on ticks from a power-of-two prescaler that sits on the kernel clock. The counter runs from zero up to a reload value and then wraps. The output is active while the count is above a compare value. Software programs the block through a small synchronous register bus with write, read, byte address and data lines. Read data is registered and appears one cycle after the read strobe.

The block uses a fixed programming order. With the timer disabled, software sets the division exponent and the polarity. It then enables the timer and writes the reload and compare values. It waits for the per-register OK flags and then issues the start command. To get a period of P ticks with an active time of D ticks, software writes P-1 to the reload register and P-1-D to the compare register. New compare or reload values written while the counter runs are held in a preload stage. They move to the working registers at the next wrap, so a period is never cut short.

Register map (byte offsets): control 0x00, configuration 0x04, compare 0x08, reload 0x0C, status 0x10, flag clear 0x14. Other addresses read as zero.

Top module: `lpwm_timer`

## Requirements
- R1: Configuration bits [2:0] hold an exponent N. The counter advances once every 2^N clock cycles, so N=0 gives a ratio of 1 and N=7 gives a ratio of 128.
- R2: A write to configuration (exponent at bits [2:0], polarity at bit 4) takes effect only while the enable bit is 0. Writes made while enabled leave the read-back value unchanged.
- R3: Writes to compare (0x08) or reload (0x0C) are ignored while the timer is disabled. The read-back value stays the same and no OK flag is set.
- R4: While running, the counter cycles from 0 to the reload value inclusive. The output period is (reload+1)*2^N clock cycles.
- R5: The output is active while the counter is strictly greater than compare, which gives (reload-compare)*2^N active cycles per period.
- R6: Polarity bit 1 inverts the output waveform.
- R7: In control, bit 0 is enable and bit 1 is run. Counting starts only on a control write with both bits set. A control write with bit 0 clear disables the timer and stops the counter. Control reads back with enable at bit 0 and running at bit 1.
- R8: Compare and reload writes made while running move to the working registers only at the next counter wrap. While enabled and not running, they move on the next clock.
- R9: Status bit 0 (compare OK) and bit 1 (reload OK) are sticky. Each is set on the third clock edge after the write edge when the timer is enabled and idle. A status read issued on the fourth edge after the write is the first to return the flag set.
- R10: Writing a 1 to a bit of the clear register (0x14) clears the matching status flag. Bits written as 0 leave their flags untouched.
- R11: The output is 0 while disabled. While enabled but not running, the output sits at its inactive level, which equals the polarity bit. Both apply from the second clock edge after the control write.
- R12: After reset the reload value is 0xFFFF, compare is 0, control, configuration and status are 0, and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write takes effect on the clock edge where it is sampled. Read data lags the read strobe by one edge. The output register lags the counter and the control state by one more edge, so output checks are made two negative edges after a control write. The OK-flag timing is checked with four back-to-back status reads issued right after the write edge, and the expected pattern is 0,0,0,1. Waveform results are checked by counting active cycles over exactly one period after the output has settled for two periods, and by timing the gap between rising edges. These counts do not depend on the phase at which the count starts.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int A_CTRL = 'h00;
  localparam int A_CFG  = 'h04;
  localparam int A_CMP  = 'h08;
  localparam int A_ARR  = 'h0C;
  localparam int A_STAT = 'h10;
  localparam int A_CLR  = 'h14;

  localparam int B_EN   = 0;
  localparam int B_RUN  = 1;
  localparam int B_POL  = 4;

  localparam int F_CMP  = 0;
  localparam int F_ARR  = 1;
  localparam int N_FLAG = 2;
endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs import lpwm_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              run,
  output logic [PSC_W-1:0]  psc,
  output logic              pol,
  output logic [CNT_W-1:0]  cmp_pre,
  output logic [CNT_W-1:0]  arr_pre,
  output logic              cmp_pv,
  output logic              arr_pv,
  input  logic              ld_cmp,
  input  logic              ld_arr
);
  logic hit_ctrl, hit_cfg, hit_cmp, hit_arr, hit_clr;
  logic [N_FLAG-1:0] ld_v, d1, d2, flag;
  logic [DATA_W-1:0] rmux;

  assign hit_ctrl = wr && (addr == ADDR_W'(A_CTRL));
  assign hit_cfg  = wr && (addr == ADDR_W'(A_CFG));
  assign hit_cmp  = wr && (addr == ADDR_W'(A_CMP));
  assign hit_arr  = wr && (addr == ADDR_W'(A_ARR));
  assign hit_clr  = wr && (addr == ADDR_W'(A_CLR));

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      run     <= 1'b0;
      psc     <= '0;
      pol     <= 1'b0;
      cmp_pre <= '0;
      arr_pre <= '1;
      cmp_pv  <= 1'b0;
      arr_pv  <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        en  <= wdata[B_EN];
        run <= wdata[B_EN] & (wdata[B_RUN] | run);
      end
      if (hit_cfg && !en) begin
        psc <= wdata[PSC_W-1:0];
        pol <= wdata[B_POL];
      end
      if (hit_cmp && en) begin
        cmp_pre <= wdata[CNT_W-1:0];
        cmp_pv  <= 1'b1;
      end else if (ld_cmp) begin
        cmp_pv  <= 1'b0;
      end
      if (hit_arr && en) begin
        arr_pre <= wdata[CNT_W-1:0];
        arr_pv  <= 1'b1;
      end else if (ld_arr) begin
        arr_pv  <= 1'b0;
      end
    end
  end

  assign ld_v[F_CMP] = ld_cmp;
  assign ld_v[F_ARR] = ld_arr;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        d1[i]   <= 1'b0;
        d2[i]   <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        d1[i] <= ld_v[i];
        d2[i] <= d1[i];
        if (d2[i])                     flag[i] <= 1'b1;
        else if (hit_clr && wdata[i])  flag[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rmux[B_EN]  = en;
      rmux[B_RUN] = run;
    end else if (addr == ADDR_W'(A_CFG)) begin
      rmux[PSC_W-1:0] = psc;
      rmux[B_POL]     = pol;
    end else if (addr == ADDR_W'(A_CMP)) begin
      rmux = DATA_W'(cmp_pre);
    end else if (addr == ADDR_W'(A_ARR)) begin
      rmux = DATA_W'(arr_pre);
    end else if (addr == ADDR_W'(A_STAT)) begin
      rmux[N_FLAG-1:0] = flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  // R2: configuration frozen while enabled
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (rst)
    en && hit_cfg |=> $stable(psc) && $stable(pol));
  // R3: compare/reload preload untouched while disabled
  p_cmp_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    !en && hit_cmp |=> $stable(cmp_pre));
  p_arr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    !en && hit_arr |=> $stable(arr_pre));
  // R7: a control write with enable clear stops everything
  p_stop_r7: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl && !wdata[B_EN] |=> !run && !en);
  // R9: flags are sticky until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    flag[F_CMP] && !(hit_clr && wdata[F_CMP]) |=> flag[F_CMP]);
  // R10: clear removes the flag unless a set arrives in the same cycle
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    hit_clr && wdata[F_ARR] && !d2[F_ARR] |=> !flag[F_ARR]);
endmodule

// File: rtl/lpwm_prescaler.sv
module lpwm_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] mask;

  always_comb mask = DIV_W'((32'd1 << psc) - 32'd1);

  assign tick = run && ((pc & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else             pc <= pc + 1'b1;
  end

  // R1: ratio 1 ticks every cycle while running
  p_div1_r1: assert property (@(posedge clk) disable iff (rst)
    run && (psc == '0) |-> tick);
  // R1: no tick while stopped
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);
endmodule

// File: rtl/lpwm_core.sv
module lpwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic             pol,
  input  logic [CNT_W-1:0] cmp_pre,
  input  logic [CNT_W-1:0] arr_pre,
  input  logic             cmp_pv,
  input  logic             arr_pv,
  output logic             ld_cmp,
  output logic             ld_arr,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt, cmp_act, arr_act;
  logic wrap, load_ok;

  assign wrap    = tick && (cnt == arr_act);
  assign load_ok = en && (!run || wrap);
  assign ld_cmp  = load_ok && cmp_pv;
  assign ld_arr  = load_ok && arr_pv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmp_act <= '0;
      arr_act <= '1;
      pwm_out <= 1'b0;
    end else begin
      if (ld_cmp) cmp_act <= cmp_pre;
      if (ld_arr) arr_act <= arr_pre;
      if (!run)      cnt <= '0;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      pwm_out <= en ? ((run && (cnt > cmp_act)) ^ pol) : 1'b0;
    end
  end

  // R4: counter never exceeds the working reload value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= arr_act);
  // R8: working values only change at a wrap while running
  p_load_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    run && !wrap |=> $stable(cmp_act) && $stable(arr_act));
  // R11: stopped counter rests at zero
  p_rest_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/lpwm_timer.sv
module lpwm_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic en, run, pol, tick;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cmp_pre, arr_pre;
  logic cmp_pv, arr_pv, ld_cmp, ld_arr;

  lpwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .run(run), .psc(psc),
    .pol(pol), .cmp_pre(cmp_pre), .arr_pre(arr_pre), .cmp_pv(cmp_pv),
    .arr_pv(arr_pv), .ld_cmp(ld_cmp), .ld_arr(ld_arr)
  );

  lpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .psc(psc), .tick(tick)
  );

  lpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(en), .run(run), .tick(tick), .pol(pol),
    .cmp_pre(cmp_pre), .arr_pre(arr_pre), .cmp_pv(cmp_pv), .arr_pv(arr_pv),
    .ld_cmp(ld_cmp), .ld_arr(ld_arr), .pwm_out(pwm_out)
  );

  // R11: output low one edge after the timer is disabled
  p_out_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);
endmodule

// File: tb/lpwm_timer_bench.sv
module lpwm_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwm_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpwm_timer u_lpwm_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic prog(input int n, input bit p, input int a, input int c);
    wr_reg(5'h00, 0);
    wr_reg(5'h04, (p << 4) | n);
    wr_reg(5'h00, 1);
    wr_reg(5'h0C, a);
    wr_reg(5'h08, c);
    repeat (6) @(negedge clk);
    wr_reg(5'h14, 3);
    wr_reg(5'h00, 3);
  endtask

  task automatic measure(input int win, output int hi, output int per);
    bit prev;
    repeat (2 * win) @(negedge clk);
    hi = 0;
    for (int i = 0; i < win; i++) begin @(negedge clk); if (pwm_out) hi++; end
    prev = pwm_out;
    for (int i = 0; i < 3 * win; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) break;
      prev = pwm_out;
    end
    per = 0;
    prev = pwm_out;
    for (int i = 0; i < 3 * win; i++) begin
      @(negedge clk); per++;
      if (!prev && pwm_out) break;
      prev = pwm_out;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R12 out", {31'd0, pwm_out}, 0);
    rd_reg(5'h0C, v); chk("R12 reload", v, 32'hFFFF);
    rd_reg(5'h08, v); chk("R12 compare", v, 0);
    rd_reg(5'h10, v); chk("R12 status", v, 0);
    rd_reg(5'h00, v); chk("R12 control", v, 0);
    rd_reg(5'h04, v); chk("R12 config", v, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr_reg(5'h0C, 5);
    wr_reg(5'h08, 7);
    repeat (5) @(negedge clk);
    rd_reg(5'h0C, v); chk("R3 reload kept", v, 32'hFFFF);
    rd_reg(5'h08, v); chk("R3 compare kept", v, 0);
    rd_reg(5'h10, v); chk("R3 no flag", v, 0);
  endtask

  task automatic t_cfg_lock;
    logic [31:0] v;
    wr_reg(5'h04, 32'h12);
    rd_reg(5'h04, v); chk("R2 cfg written", v, 32'h12);
    wr_reg(5'h00, 1);
    wr_reg(5'h04, 32'h05);
    rd_reg(5'h04, v); chk("R2 cfg locked", v, 32'h12);
  endtask

  task automatic t_flags;
    logic [31:0] s [4];
    logic [31:0] v;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 3;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 5'h10;
    for (int i = 0; i < 4; i++) begin @(negedge clk); s[i] = bus_rdata; end
    bus_rd = 1'b0;
    chk("R9 edge1", s[0], 0);
    chk("R9 edge2", s[1], 0);
    chk("R9 edge3", s[2], 0);
    chk("R9 edge4", s[3], 1);
    rd_reg(5'h08, v); chk("R8 idle compare load", v, 3);
    wr_reg(5'h14, 2);
    rd_reg(5'h10, v); chk("R10 other bit kept", v, 1);
    wr_reg(5'h14, 1);
    rd_reg(5'h10, v); chk("R10 cleared", v, 0);
  endtask

  task automatic t_wave(input string tag, input int n, input bit p, input int a, input int c);
    int hi, per, win;
    win = (a + 1) << n;
    prog(n, p, a, c);
    measure(win, hi, per);
    if (p) hi = win - hi;
    chk({tag, " active"}, hi, (a - c) << n);
    chk({tag, " period"}, per, win);
  endtask

  task automatic t_reload_running;
    logic [31:0] v;
    int hi, per;
    prog(0, 0, 199, 100);
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (pwm_out) break; end
    wr_reg(5'h0C, 49);
    wr_reg(5'h08, 20);
    rd_reg(5'h10, v); chk("R8 no load before wrap", v, 0);
    repeat (300) @(negedge clk);
    rd_reg(5'h10, v); chk("R8 loaded after wrap", v, 3);
    measure(50, hi, per);
    chk("R8 new active", hi, 29);
    chk("R8 new period", per, 50);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr_reg(5'h00, 0);
    @(negedge clk); chk("R11 disabled out", {31'd0, pwm_out}, 0);
    rd_reg(5'h00, v); chk("R7 stopped", v, 0);
    wr_reg(5'h00, 2);
    rd_reg(5'h00, v); chk("R7 run without enable", v, 0);
    chk("R11 still low", {31'd0, pwm_out}, 0);
    wr_reg(5'h04, 32'h10);
    wr_reg(5'h00, 1);
    @(negedge clk); chk("R11 idle at polarity", {31'd0, pwm_out}, 1);
    wr_reg(5'h00, 0);
    wr_reg(5'h00, 3);
    rd_reg(5'h00, v); chk("R7 started", v, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ignored();
    t_cfg_lock();
    t_flags();
    t_wave("R5 div1", 0, 0, 9, 6);
    t_wave("R1 div4", 2, 0, 7, 2);
    t_wave("R1 div128", 7, 0, 3, 1);
    t_wave("R6 inverted", 1, 1, 11, 4);
    t_wave("R4 zero compare", 0, 0, 4, 0);
    t_reload_running();
    t_ctrl();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule